// File: doc/BRIEF.md
# Two-Bank Synchronous DRAM Command Decoder

This block sits at the front of a two-bank synchronous graphics DRAM model. On every rising clock edge it samples the command strobes, clock enable, bank select and a 10-bit address bus. It turns what it samples into activate, read, write, precharge or idle events. It keeps, for each bank, whether the bank is open and which row it holds. It also runs a fixed-length burst timer, so that a read or write that asks for auto-precharge closes its bank when the burst ends.

The outputs are all registered: the accepted command, the last captured row and column, the bank that the last accepted command targeted, the per-bank open flags and open rows, a burst-in-progress flag, and a one-cycle error pulse for commands that break the bank protocol. The data path, masked block writes, the mode register and refresh timing belong to other blocks.

Top module: `sgr_cmd_decoder`

## Requirements
- R1: On a rising edge where `cke` is low, no state changes: the open flags, rows, outputs and burst timer all keep their values, and no command is taken.
- R2: On an edge where `cke` is high and `cs_n` is high, no command is taken. `cmd_o` shows idle (0), and a burst already in progress keeps counting to its end.
- R3: With `cs_n` low, the strobes {`ras_n`,`cas_n`,`we_n`} decode as follows: 011 is activate (code 1), 101 is read (code 2), 100 is write (code 3), 010 is precharge (code 4). Every other pattern is idle (code 0). `cmd_o` shows the code of the command accepted at the previous edge.
- R4: An activate to a closed bank opens that bank and stores `addr[9:0]` as its row. The same value appears on `row_o`, and the bank appears on `bank_o`.
- R5: A read or write to an open bank places `addr[7:0]` on `col_o`. `burst_active` is then high for exactly BURST_LEN cycles, starting in the cycle after the command edge.
- R6: A read or write taken with `addr[8]` high closes its bank on the edge that ends the burst, BURST_LEN edges after the command. With `addr[8]` low the bank stays open.
- R7: A precharge with `addr[8]` high closes both banks whatever `bank_sel` is. With `addr[8]` low it closes only the bank that `bank_sel` names. Precharge of a closed bank is legal.
- R8: `bank_sel` = 0 addresses bank A: `bank_open[0]` and `open_rows[9:0]`. `bank_sel` = 1 addresses bank B: `bank_open[1]` and `open_rows[19:10]`.
- R9: The following commands are rejected: an activate to an open bank; a read or write to a closed bank; a read or write while the running burst has more than one edge left. A rejected command changes no state, shows idle on `cmd_o`, and raises `err_o` for one cycle. A bank that auto-precharge closes on the same edge counts as already closed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge samples all inputs |
| rst_n | input | 1 | Asynchronous active-low reset |
| cke | input | 1 | Clock enable, low freezes the block |
| cs_n | input | 1 | Active-low chip select |
| ras_n | input | 1 | Active-low row strobe |
| cas_n | input | 1 | Active-low column strobe |
| we_n | input | 1 | Active-low write enable |
| bank_sel | input | 1 | Bank select, 0 = bank A, 1 = bank B |
| addr | input | 10 | Row address, or column plus auto-precharge/all-banks bit 8 |
| cmd_o | output | 3 | Accepted command code |
| row_o | output | 10 | Row of the last accepted activate |
| col_o | output | 8 | Column of the last accepted read or write |
| bank_o | output | 1 | Bank of the last accepted activate, read, write or precharge |
| bank_open | output | 2 | Per-bank open flags |
| open_rows | output | 20 | Per-bank open row, bank A in the low half |
| burst_active | output | 1 | A read or write burst is in progress |
| err_o | output | 1 | One-cycle pulse for a rejected command |

## Verification
A wrong bank state shows up at the ports no later than the cycle after the faulty edge. A flag that is open when it should be closed, or a stale row, is visible on `bank_open` and `open_rows`. It also changes how later commands are accepted, because the next activate, read or write to that bank flips `err_o` and `cmd_o`. A burst timer that is off by one moves the fall of `burst_active`, and it moves the auto-precharge close on `bank_open` to the same wrong edge. A protocol-aware reference model compared every cycle catches any of these within one clock.

// File: rtl/sgr_cmd_pkg.sv
package sgr_cmd_pkg;

  typedef enum logic [2:0] {
    CMD_NOP = 3'd0,
    CMD_ACT = 3'd1,
    CMD_RD  = 3'd2,
    CMD_WR  = 3'd3,
    CMD_PRE = 3'd4
  } sgr_cmd_e;

  // Strobes are active low; unlisted patterns fall back to idle.
  function automatic sgr_cmd_e decode_strobes(input logic ras_n,
                                              input logic cas_n,
                                              input logic we_n);
    case ({ras_n, cas_n, we_n})
      3'b011:  return CMD_ACT;
      3'b101:  return CMD_RD;
      3'b100:  return CMD_WR;
      3'b010:  return CMD_PRE;
      default: return CMD_NOP;
    endcase
  endfunction

  function automatic logic is_column_cmd(input sgr_cmd_e c);
    return (c == CMD_RD) || (c == CMD_WR);
  endfunction

endpackage

// File: rtl/sgr_bank_slot.sv
module sgr_bank_slot #(
  parameter int ROW_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cke,
  input  logic             do_open,
  input  logic             do_close,
  input  logic [ROW_W-1:0] row_in,
  output logic             is_open,
  output logic [ROW_W-1:0] row
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      is_open <= 1'b0;
      row     <= '0;
    end else if (cke) begin
      // Opening wins: an activate is only accepted once the bank counts as closed.
      if (do_open) begin
        is_open <= 1'b1;
        row     <= row_in;
      end else if (do_close) begin
        is_open <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/sgr_burst_ctr.sv
module sgr_burst_ctr #(
  parameter int BURST_LEN = 4,
  parameter int BANK_W    = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cke,
  input  logic              start,
  input  logic              start_ap,
  input  logic [BANK_W-1:0] start_bank,
  output logic              active,
  output logic              busy,
  output logic [(1<<BANK_W)-1:0] close_vec
);

  localparam int BANKS = 1 << BANK_W;
  localparam int CNT_W = (BURST_LEN > 1) ? $clog2(BURST_LEN) : 1;
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(BURST_LEN - 1);

  logic [CNT_W-1:0]  cnt_q;
  logic              ap_q;
  logic [BANK_W-1:0] bank_q;
  logic              last_edge;

  assign last_edge = active && (cnt_q == '0);
  assign busy      = active && (cnt_q != '0);

  always_comb begin
    close_vec = '0;
    if (last_edge && ap_q) close_vec[bank_q] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      cnt_q  <= '0;
      ap_q   <= 1'b0;
      bank_q <= '0;
    end else if (cke) begin
      if (start) begin
        active <= 1'b1;
        cnt_q  <= CNT_LOAD;
        ap_q   <= start_ap;
        bank_q <= start_bank;
      end else if (last_edge) begin
        active <= 1'b0;
        ap_q   <= 1'b0;
      end else if (active) begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  initial begin
    if (BANKS < 2) $error("sgr_burst_ctr: need at least two banks");
  end

endmodule

// File: rtl/sgr_cmd_decoder.sv
module sgr_cmd_decoder
  import sgr_cmd_pkg::*;
#(
  parameter int ROW_W     = 10,
  parameter int COL_W     = 8,
  parameter int AP_BIT    = 8,
  parameter int BANK_W    = 1,
  parameter int BURST_LEN = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         cke,
  input  logic                         cs_n,
  input  logic                         ras_n,
  input  logic                         cas_n,
  input  logic                         we_n,
  input  logic [BANK_W-1:0]            bank_sel,
  input  logic [ROW_W-1:0]             addr,
  output logic [2:0]                   cmd_o,
  output logic [ROW_W-1:0]             row_o,
  output logic [COL_W-1:0]             col_o,
  output logic [BANK_W-1:0]            bank_o,
  output logic [(1<<BANK_W)-1:0]       bank_open,
  output logic [(1<<BANK_W)*ROW_W-1:0] open_rows,
  output logic                         burst_active,
  output logic                         err_o
);

  localparam int BANKS = 1 << BANK_W;

  // Named internal events, also seen by the bound checker.
  sgr_cmd_e         raw_cmd;
  sgr_cmd_e         acc_cmd;
  logic [BANKS-1:0] ap_close;
  logic [BANKS-1:0] eff_open;
  logic [BANKS-1:0] pre_mask;
  logic             tgt_open;
  logic             burst_busy;
  logic             act_ok, act_bad;
  logic             rw_req, rw_ok, rw_bad;
  logic             pre_ok;
  logic             all_banks;

  assign raw_cmd   = cs_n ? CMD_NOP : decode_strobes(ras_n, cas_n, we_n);
  assign all_banks = addr[AP_BIT];

  // An auto-precharge firing on this edge already counts as closed.
  assign eff_open = bank_open & ~ap_close;
  assign tgt_open = eff_open[bank_sel];

  assign act_ok  = (raw_cmd == CMD_ACT) && !tgt_open;
  assign act_bad = (raw_cmd == CMD_ACT) &&  tgt_open;
  assign rw_req  = is_column_cmd(raw_cmd);
  assign rw_ok   = rw_req && tgt_open && !burst_busy;
  assign rw_bad  = rw_req && !rw_ok;
  assign pre_ok  = (raw_cmd == CMD_PRE);

  always_comb begin
    pre_mask = '0;
    if (all_banks) pre_mask = '1;
    else           pre_mask[bank_sel] = 1'b1;
  end

  always_comb begin
    if (act_ok)      acc_cmd = CMD_ACT;
    else if (rw_ok)  acc_cmd = raw_cmd;
    else if (pre_ok) acc_cmd = CMD_PRE;
    else             acc_cmd = CMD_NOP;
  end

  sgr_burst_ctr #(
    .BURST_LEN (BURST_LEN),
    .BANK_W    (BANK_W)
  ) burst_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .cke        (cke),
    .start      (rw_ok),
    .start_ap   (all_banks),
    .start_bank (bank_sel),
    .active     (burst_active),
    .busy       (burst_busy),
    .close_vec  (ap_close)
  );

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    logic slot_open;
    logic slot_close;
    assign slot_open  = act_ok && (bank_sel == BANK_W'(b));
    assign slot_close = ap_close[b] || (pre_ok && pre_mask[b]);

    sgr_bank_slot #(.ROW_W(ROW_W)) slot_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .cke      (cke),
      .do_open  (slot_open),
      .do_close (slot_close),
      .row_in   (addr),
      .is_open  (bank_open[b]),
      .row      (open_rows[b*ROW_W +: ROW_W])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_o  <= CMD_NOP;
      err_o  <= 1'b0;
      row_o  <= '0;
      col_o  <= '0;
      bank_o <= '0;
    end else if (cke) begin
      cmd_o <= acc_cmd;
      err_o <= act_bad || rw_bad;
      if (act_ok) row_o <= addr;
      if (rw_ok)  col_o <= addr[COL_W-1:0];
      if (act_ok || rw_ok || pre_ok) bank_o <= bank_sel;
    end
  end

endmodule

// File: rtl/sgr_cmd_checker.sv
module sgr_cmd_checker #(
  parameter int BANK_W = 1,
  parameter int AP_BIT = 8,
  parameter int ROW_W  = 10
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   cke,
  input logic                   cs_n,
  input logic [ROW_W-1:0]       addr,
  input logic [BANK_W-1:0]      bank_sel,
  input logic [2:0]             cmd_o,
  input logic [(1<<BANK_W)-1:0] bank_open,
  input logic                   burst_active,
  input logic                   err_o,
  input logic                   act_ok,
  input logic                   rw_ok,
  input logic                   pre_ok
);

  AST_CKE_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    !cke |=> $stable(bank_open) && $stable(cmd_o) && $stable(burst_active)); // R1

  AST_DESELECT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    cke && cs_n |=> cmd_o == 3'd0); // R2

  AST_ACT_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
    cke && act_ok |=> bank_open[$past(bank_sel)]); // R4

  AST_RW_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
    cke && rw_ok |=> burst_active && bank_open[$past(bank_sel)]); // R5

  AST_PRE_ALL_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
    cke && pre_ok && addr[AP_BIT] |=> bank_open == '0); // R7

  AST_ERR_IS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> cmd_o == 3'd0); // R9

endmodule

bind sgr_cmd_decoder sgr_cmd_checker #(
  .BANK_W (BANK_W),
  .AP_BIT (AP_BIT),
  .ROW_W  (ROW_W)
) chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .cke          (cke),
  .cs_n         (cs_n),
  .addr         (addr),
  .bank_sel     (bank_sel),
  .cmd_o        (cmd_o),
  .bank_open    (bank_open),
  .burst_active (burst_active),
  .err_o        (err_o),
  .act_ok       (act_ok),
  .rw_ok        (rw_ok),
  .pre_ok       (pre_ok)
);

// File: tb/sgr_cmd_decoder_tb_top.sv
module sgr_cmd_decoder_tb_top;

  localparam int BL = 4;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic       rst_n, cke, cs_n, ras_n, cas_n, we_n;
  logic [0:0] bank_sel;
  logic [9:0] addr;
  logic [2:0] cmd_o;
  logic [9:0] row_o;
  logic [7:0] col_o;
  logic [0:0] bank_o;
  logic [1:0] bank_open;
  logic [19:0] open_rows;
  logic       burst_active, err_o;

  sgr_cmd_decoder #(.BURST_LEN(BL)) dut_i (
    .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
    .cas_n(cas_n), .we_n(we_n), .bank_sel(bank_sel), .addr(addr),
    .cmd_o(cmd_o), .row_o(row_o), .col_o(col_o), .bank_o(bank_o),
    .bank_open(bank_open), .open_rows(open_rows),
    .burst_active(burst_active), .err_o(err_o)
  );

  int n_chk = 0;
  int n_fail = 0;

  // Behavioural reference model, stepped on each rising edge.
  int m_open[2], m_row[2];
  int m_cmd, m_rowo, m_col, m_bank, m_err, m_bact, m_left, m_ap, m_apb;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_open = '{0, 0}; m_row = '{0, 0};
      m_cmd = 0; m_rowo = 0; m_col = 0; m_bank = 0; m_err = 0;
      m_bact = 0; m_left = 0; m_ap = 0; m_apb = 0;
    end else if (cke) begin
      int code, busy, ba;
      busy = 0;
      if (m_bact) begin
        if (m_left == 0) begin
          m_bact = 0;
          if (m_ap) m_open[m_apb] = 0;
        end else begin
          busy = 1;
          m_left--;
        end
      end
      code = 0;
      if (!cs_n)
        case ({ras_n, cas_n, we_n})
          3'b011: code = 1;
          3'b101: code = 2;
          3'b100: code = 3;
          3'b010: code = 4;
          default: code = 0;
        endcase
      ba = int'(bank_sel);
      m_err = 0; m_cmd = 0;
      if (code == 1) begin
        if (m_open[ba] != 0) m_err = 1;
        else begin
          m_open[ba] = 1; m_row[ba] = int'(addr);
          m_rowo = int'(addr); m_bank = ba; m_cmd = 1;
        end
      end else if (code == 2 || code == 3) begin
        if (m_open[ba] == 0 || busy != 0) m_err = 1;
        else begin
          m_col = int'(addr[7:0]); m_bank = ba; m_cmd = code;
          m_bact = 1; m_left = BL - 1; m_ap = int'(addr[8]); m_apb = ba;
        end
      end else if (code == 4) begin
        if (addr[8]) m_open = '{0, 0};
        else m_open[ba] = 0;
        m_bank = ba; m_cmd = 4;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic compare();
    chk(int'(cmd_o) == m_cmd, "R3", "cmd_o", int'(cmd_o), m_cmd);
    chk(int'(row_o) == m_rowo, "R4", "row_o", int'(row_o), m_rowo);
    chk(int'(col_o) == m_col, "R5", "col_o", int'(col_o), m_col);
    chk(int'(bank_o) == m_bank, "R8", "bank_o", int'(bank_o), m_bank);
    chk(int'(bank_open[0]) == m_open[0], "R6", "bank A open", int'(bank_open[0]), m_open[0]);
    chk(int'(bank_open[1]) == m_open[1], "R7", "bank B open", int'(bank_open[1]), m_open[1]);
    chk(int'(open_rows[9:0]) == m_row[0], "R8", "bank A row", int'(open_rows[9:0]), m_row[0]);
    chk(int'(open_rows[19:10]) == m_row[1], "R8", "bank B row", int'(open_rows[19:10]), m_row[1]);
    chk(int'(burst_active) == m_bact, "R5", "burst_active", int'(burst_active), m_bact);
    chk(int'(err_o) == m_err, "R9", "err_o", int'(err_o), m_err);
  endtask

  // s = {ras_n,cas_n,we_n}
  task automatic cyc(input bit ck, input bit cs, input logic [2:0] s,
                     input bit ba, input int a);
    @(negedge clk);
    compare();
    cke = ck; cs_n = cs; {ras_n, cas_n, we_n} = s; bank_sel = ba; addr = 10'(a);
  endtask

  localparam logic [2:0] S_ACT = 3'b011, S_RD = 3'b101, S_WR = 3'b100,
                         S_PRE = 3'b010, S_NOP = 3'b111;

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; cke = 1'b1; cs_n = 1'b1; {ras_n, cas_n, we_n} = S_NOP;
    bank_sel = 1'b0; addr = '0;
    repeat (3) @(negedge clk);
    chk(bank_open == 2'b00 && cmd_o == 3'd0 && !err_o && !burst_active,
        "R1", "reset state", int'(bank_open), 0);
    rst_n = 1'b1;
    // R4 R8: open A with row 0x155, B with row 0x2AA
    cyc(1, 0, S_ACT, 0, 'h155);
    cyc(1, 0, S_ACT, 1, 'h2AA);
    cyc(1, 0, S_ACT, 0, 'h001);          // R9 activate to open bank
    cyc(1, 0, S_NOP, 0, 0);
    chk(err_o == 1'b1, "R9", "activate open bank err", int'(err_o), 1);
    // R1: precharge-all with cke low must not close anything
    cyc(0, 0, S_PRE, 0, 'h100);
    cyc(1, 1, S_NOP, 0, 0);
    chk(bank_open == 2'b11, "R1", "cke low ignores precharge", int'(bank_open), 3);
    // R5 R6: read A with auto-precharge, column 0x3C
    cyc(1, 0, S_RD, 0, 'h13C);
    cyc(1, 1, S_PRE, 1, 'h100);          // R2 deselected precharge ignored
    chk(bank_open == 2'b11 && burst_active, "R2", "deselect keeps banks/burst", int'(bank_open), 3);
    cyc(1, 0, S_WR, 1, 'h022);           // R9 busy burst
    cyc(1, 0, S_NOP, 0, 0);
    cyc(1, 0, S_NOP, 0, 0);
    chk(bank_open[0] == 1'b1, "R6", "bank A open before burst end", int'(bank_open[0]), 1);
    cyc(1, 0, S_NOP, 0, 0);
    chk(bank_open[0] == 1'b0 && !burst_active, "R6", "auto-precharge closes A", int'(bank_open[0]), 0);
    // R9: read to closed A
    cyc(1, 0, S_RD, 0, 'h005);
    // write B without auto-precharge, then back-to-back at final edge
    cyc(1, 0, S_WR, 1, 'h07F);
    repeat (BL - 1) cyc(1, 0, S_NOP, 0, 0);
    cyc(1, 0, S_RD, 1, 'h011);
    cyc(1, 0, S_NOP, 0, 0);
    chk(bank_open[1] == 1'b1 && col_o == 8'h11, "R6", "no-ap keeps B open", int'(col_o), 'h11);
    // R7: single-bank precharge then all-bank precharge
    cyc(1, 0, S_ACT, 0, 'h3FF);
    cyc(1, 0, S_PRE, 1, 'h000);
    cyc(1, 0, S_NOP, 0, 0);
    chk(bank_open == 2'b01, "R7", "precharge B only", int'(bank_open), 1);
    cyc(1, 0, S_ACT, 1, 'h044);
    cyc(1, 0, S_PRE, 0, 'h100);
    cyc(1, 0, S_NOP, 0, 0);
    chk(bank_open == 2'b00, "R7", "precharge all", int'(bank_open), 0);
    // R3: undefined strobe patterns are idle
    cyc(1, 0, 3'b001, 0, 0);
    cyc(1, 0, 3'b000, 1, 0);
    cyc(1, 0, S_NOP, 0, 0);
    chk(cmd_o == 3'd0 && bank_open == 2'b00, "R3", "undefined pattern idle", int'(cmd_o), 0);
    // Random traffic
    for (int i = 0; i < 4000; i++) begin
      int r;
      r = int'($urandom_range(0, 99));
      cyc(r < 90, r > 85, 3'($urandom_range(0, 7)), 1'($urandom_range(0, 1)),
          int'($urandom_range(0, 1023)));
    end
    cyc(1, 1, S_NOP, 0, 0);
    cyc(1, 1, S_NOP, 0, 0);
    finish_run();
  end

endmodule